// File: doc/BRIEF.md
# UART Banked Register Front End

This block is the bus-side register window of a UART. It decodes a four-word address space and turns single-cycle bus accesses into pulses for a receive FIFO and a transmit FIFO. It also holds the configuration state: a line-control byte and a 16-bit baud divisor split into two bytes. A bank bit in the line-control byte decides what the two lower word offsets reach. When the bank bit is clear, offset 0x0 is the data port: a read takes the oldest received byte and a write queues a byte for sending. When the bank bit is set, offsets 0x0 and 0x4 hold the divisor bytes instead.

The FIFOs, the serial shifters, the baud generator and any interrupt logic sit outside the block and connect through its ports. Receive bytes of characters shorter than 8 bits are masked so that unused upper bits read as zero. Every output is registered on the bus clock, so a bus access gives its result one cycle later.

Top module: `uart_bank_regs`

## Requirements
- R1: While reset is asserted, bus_rdata_o is 0x00, rx_pop_o, tx_push_o and tx_ovf_o are 0, tx_data_o is 0x00, lcr_o is 0x03 and divisor_o is 0x0001.
- R2: With bank bit clear, a read at offset 0x0 while rx_empty_i is low loads the masked rx_data_i into bus_rdata_o and raises rx_pop_o for exactly one cycle, both visible in the cycle after the access.
- R3: A read at offset 0x0 with bank bit clear while rx_empty_i is high leaves bus_rdata_o at its last value and produces no pop.
- R4: With bank bit clear, a write at offset 0x0 while tx_full_i is low raises tx_push_o for one cycle with tx_data_o equal to the written byte, unchanged in bit order (bit 0 is the first bit sent), in the cycle after the access.
- R5: A write at offset 0x0 with bank bit clear while tx_full_i is high produces no push and sets tx_ovf_o, which then stays set until reset.
- R6: Writes never change bus_rdata_o, and reads never produce a push.
- R7: With bank bit set, offset 0x0 reads and writes the divisor low byte and offset 0x4 the high byte, with no pop or push. The divisor does not change while the bank bit is clear.
- R8: divisor_o equals {high byte, low byte}, except that a zero divisor is output as 0x0001. Reads still return the raw stored bytes.
- R9: The line-control byte at offset 0xC can be read and written in either bank, and its bit 7 is the bank bit.
- R10: Line-control bits [1:0] give the character length as 5 + value bits. Receive bytes returned at offset 0x0 have all bits at and above that length cleared.
- R11: Reads at offset 0x8, at offset 0x4 with bank bit clear, or at any address with bits [1:0] non-zero return 0x00. Writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address of the access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| rx_data_i | input | 8 | Oldest byte of the receive FIFO |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_pop_o | output | 1 | Pop pulse to the receive FIFO |
| tx_full_i | input | 1 | Transmit FIFO full |
| tx_data_o | output | 8 | Byte to push into the transmit FIFO |
| tx_push_o | output | 1 | Push pulse to the transmit FIFO |
| tx_ovf_o | output | 1 | Sticky flag for a dropped transmit write |
| lcr_o | output | 8 | Line-control byte |
| divisor_o | output | 16 | Effective baud divisor |

## Verification
Every result of an access is due one clock edge after the edge that samples it: read data, the pop and push pulses, the overflow flag, and the new line-control and divisor values. The bench drives each access on a falling edge. It checks all outputs on the next falling edge against a model updated from the same stimulus. It then holds an idle cycle and checks that the pulses have dropped and the read data has held.

// File: rtl/uart_bank_pkg.sv
`timescale 1ns/1ps
package uart_bank_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned DIV_W    = 2 * DATA_W;
  localparam int unsigned WORD_DAT = 0;
  localparam int unsigned WORD_DHI = 1;
  localparam int unsigned WORD_LCR = 3;
  localparam int unsigned BANK_BIT = 7;
  localparam logic [DATA_W-1:0] LCR_RST = 8'h03;
  localparam logic [DATA_W-1:0] DLO_RST = 8'h01;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_RX_RD, ACC_TX_WR, ACC_DLO_RD, ACC_DLO_WR,
    ACC_DHI_RD, ACC_DHI_WR, ACC_LCR_RD, ACC_LCR_WR, ACC_VOID_RD
  } acc_e;

  // character length 5..8 bits from lcr[1:0]
  function automatic logic [DATA_W-1:0] len_mask(logic [1:0] len);
    return {DATA_W{1'b1}} >> (2'd3 - len);
  endfunction
endpackage

// File: rtl/ubr_decode.sv
`timescale 1ns/1ps
module ubr_decode
  import uart_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  output acc_e              acc_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    acc_o = ACC_NONE;
    if (sel_i) begin
      if (addr_i[1:0] != 2'b00) begin
        acc_o = we_i ? ACC_NONE : ACC_VOID_RD;
      end else if (word == WORD_W'(WORD_DAT)) begin
        if (bank_i) acc_o = we_i ? ACC_DLO_WR : ACC_DLO_RD;
        else        acc_o = we_i ? ACC_TX_WR  : ACC_RX_RD;
      end else if (word == WORD_W'(WORD_DHI) && bank_i) begin
        acc_o = we_i ? ACC_DHI_WR : ACC_DHI_RD;
      end else if (word == WORD_W'(WORD_LCR)) begin
        acc_o = we_i ? ACC_LCR_WR : ACC_LCR_RD;
      end else begin
        acc_o = we_i ? ACC_NONE : ACC_VOID_RD;
      end
    end
  end
endmodule

// File: rtl/ubr_cfg_regs.sv
`timescale 1ns/1ps
module ubr_cfg_regs
  import uart_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lcr_o,
  output logic [DATA_W-1:0] dlo_o,
  output logic [DATA_W-1:0] dhi_o,
  output logic [DIV_W-1:0]  divisor_o
);
  logic [DIV_W-1:0] div_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_o <= LCR_RST;
      dlo_o <= DLO_RST;
      dhi_o <= '0;
    end else begin
      case (acc_i)
        ACC_LCR_WR: lcr_o <= wdata_i;
        ACC_DLO_WR: dlo_o <= wdata_i;
        ACC_DHI_WR: dhi_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assign div_raw   = {dhi_o, dlo_o};
  // zero divisor acts as one
  assign divisor_o = (div_raw == '0) ? DIV_W'(1) : div_raw;

  // R7
  div_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcr_o[BANK_BIT] |=> $stable(div_raw));
endmodule

// File: rtl/ubr_data_path.sv
`timescale 1ns/1ps
module ubr_data_path
  import uart_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_empty_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] lcr_i,
  input  logic [DATA_W-1:0] dlo_i,
  input  logic [DATA_W-1:0] dhi_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rx_pop_o  <= 1'b0;
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
      tx_ovf_o  <= 1'b0;
    end else begin
      rx_pop_o  <= 1'b0;
      tx_push_o <= 1'b0;
      case (acc_i)
        ACC_RX_RD: if (!rx_empty_i) begin
          rdata_o  <= rx_data_i & len_mask(lcr_i[1:0]);
          rx_pop_o <= 1'b1;
        end
        ACC_TX_WR: if (tx_full_i) begin
          tx_ovf_o <= 1'b1;
        end else begin
          tx_push_o <= 1'b1;
          tx_data_o <= wdata_i;
        end
        ACC_DLO_RD:  rdata_o <= dlo_i;
        ACC_DHI_RD:  rdata_o <= dhi_i;
        ACC_LCR_RD:  rdata_o <= lcr_i;
        ACC_VOID_RD: rdata_o <= '0;
        default: ;
      endcase
    end
  end

  // R2
  pop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> $past(acc_i == ACC_RX_RD && !rx_empty_i));
  // R5
  push_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(acc_i == ACC_TX_WR && !tx_full_i));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o);
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i inside {ACC_TX_WR, ACC_DLO_WR, ACC_DHI_WR, ACC_LCR_WR, ACC_NONE}) |=> $stable(rdata_o));
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_pop_o, tx_push_o}));
endmodule

// File: rtl/uart_bank_regs.sv
`timescale 1ns/1ps
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_empty_i,
  output logic              rx_pop_o,
  input  logic              tx_full_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_push_o,
  output logic              tx_ovf_o,
  output logic [DATA_W-1:0] lcr_o,
  output logic [DIV_W-1:0]  divisor_o
);
  acc_e              acc;
  logic [DATA_W-1:0] dlo, dhi;

  ubr_decode #(.ADDR_W(ADDR_W)) i_decode (
    .sel_i  (bus_sel_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .bank_i (lcr_o[BANK_BIT]),
    .acc_o  (acc)
  );

  ubr_cfg_regs i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .wdata_i   (bus_wdata_i),
    .lcr_o     (lcr_o),
    .dlo_o     (dlo),
    .dhi_o     (dhi),
    .divisor_o (divisor_o)
  );

  ubr_data_path i_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .wdata_i    (bus_wdata_i),
    .rx_data_i  (rx_data_i),
    .rx_empty_i (rx_empty_i),
    .tx_full_i  (tx_full_i),
    .lcr_i      (lcr_o),
    .dlo_i      (dlo),
    .dhi_i      (dhi),
    .rdata_o    (bus_rdata_o),
    .rx_pop_o   (rx_pop_o),
    .tx_push_o  (tx_push_o),
    .tx_data_o  (tx_data_o),
    .tx_ovf_o   (tx_ovf_o)
  );
endmodule

// File: tb/test_uart_bank_regs.sv
`timescale 1ns/1ps
module test_uart_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, rx_data = '0, tx_data, lcr;
  logic        rx_empty = 1'b1, pop, tx_full = 1'b0, push, ovf;
  logic [15:0] divisor;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [7:0] m_lcr = 8'h03, m_dlo = 8'h01, m_dhi = 8'h00, m_rd = 8'h00, m_tx = 8'h00;
  logic       m_ovf = 1'b0;

  always #2.5 clk = ~clk;

  uart_bank_regs i_uart_bank_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_data_i(rx_data), .rx_empty_i(rx_empty),
    .rx_pop_o(pop), .tx_full_i(tx_full), .tx_data_o(tx_data), .tx_push_o(push),
    .tx_ovf_o(ovf), .lcr_o(lcr), .divisor_o(divisor)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pad(input logic [7:0] d, input logic [7:0] l);
    int bits = 5 + int'(l[1:0]);
    return d & 8'((1 << bits) - 1);
  endfunction

  function automatic logic [15:0] eff_div(input logic [7:0] hi, input logic [7:0] lo);
    return ({hi, lo} == 16'h0) ? 16'h0001 : {hi, lo};
  endfunction

  task automatic access(input logic w, input logic [3:0] a, input logic [7:0] wd,
                        input logic rxe, input logic [7:0] rxd, input logic full);
    logic bank = m_lcr[7];
    logic ep = 1'b0, eh = 1'b0;
    string tag = "R11";
    sel = 1'b1; we = w; addr = a; wdata = wd;
    rx_empty = rxe; rx_data = rxd; tx_full = full;
    if (a[1:0] != 2'b00) begin
      if (!w) m_rd = 8'h00;
    end else begin
      case (a[3:2])
        2'd0: if (bank) begin
          tag = "R7";
          if (w) m_dlo = wd; else m_rd = m_dlo;
        end else if (w) begin
          if (full) begin tag = "R5"; m_ovf = 1'b1; end
          else begin tag = "R4"; eh = 1'b1; m_tx = wd; end
        end else if (rxe) tag = "R3";
        else begin tag = "R2/R10"; m_rd = pad(rxd, m_lcr); ep = 1'b1; end
        2'd1: if (bank) begin
          tag = "R7";
          if (w) m_dhi = wd; else m_rd = m_dhi;
        end else if (!w) m_rd = 8'h00;
        2'd2: if (!w) m_rd = 8'h00;
        default: begin
          tag = "R9";
          if (w) m_lcr = wd; else m_rd = m_lcr;
        end
      endcase
    end
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    chk({tag, " rdata"}, 32'(rdata), 32'(m_rd));
    chk({tag, " pop"}, 32'(pop), 32'(ep));
    chk({tag, " R6 push"}, 32'(push), 32'(eh));
    if (eh) chk("R4 tx_data", 32'(tx_data), 32'(m_tx));
    chk("R5 ovf", 32'(ovf), 32'(m_ovf));
    chk("R9 lcr", 32'(lcr), 32'(m_lcr));
    chk("R8 divisor", 32'(divisor), 32'(eff_div(m_dhi, m_dlo)));
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R2 pop pulse", 32'(pop), 32'd0);
    chk("R4 push pulse", 32'(push), 32'd0);
    chk("R3 rdata hold", 32'(rdata), 32'(m_rd));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 rdata", 32'(rdata), 32'h00);
    chk("R1 pop", 32'(pop), 32'd0);
    chk("R1 push", 32'(push), 32'd0);
    chk("R1 ovf", 32'(ovf), 32'd0);
    chk("R1 tx_data", 32'(tx_data), 32'h00);
    chk("R1 lcr", 32'(lcr), 32'h03);
    chk("R1 divisor", 32'(divisor), 32'h0001);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    access(1'b0, 4'h0, 8'h00, 1'b0, 8'hA5, 1'b0); idle();  // R2 8-bit read
    access(1'b0, 4'h0, 8'h00, 1'b1, 8'h3C, 1'b0); idle();  // R3 empty
    access(1'b1, 4'h0, 8'h96, 1'b0, 8'h00, 1'b0); idle();  // R4 push
    access(1'b1, 4'hC, 8'h00, 1'b0, 8'h00, 1'b0);          // R10 5-bit
    access(1'b0, 4'h0, 8'h00, 1'b0, 8'hFF, 1'b0); idle();
    access(1'b1, 4'hC, 8'h02, 1'b0, 8'h00, 1'b0);          // R10 7-bit
    access(1'b0, 4'h0, 8'h00, 1'b0, 8'hFF, 1'b0); idle();
    access(1'b1, 4'h0, 8'h55, 1'b0, 8'h00, 1'b1); idle();  // R5 drop
    access(1'b1, 4'h0, 8'h11, 1'b0, 8'h00, 1'b0); idle();  // R5 stays set
    access(1'b1, 4'h4, 8'h77, 1'b0, 8'h00, 1'b0); idle();  // R11 bank 0
    access(1'b0, 4'h4, 8'h00, 1'b0, 8'h00, 1'b0); idle();
    access(1'b1, 4'hC, 8'h83, 1'b0, 8'h00, 1'b0);          // R9 bank on
    access(1'b1, 4'h0, 8'h00, 1'b0, 8'h00, 1'b0);          // R8 zero divisor
    access(1'b0, 4'h0, 8'h00, 1'b0, 8'hEE, 1'b0); idle();  // R7 raw read
    access(1'b1, 4'h4, 8'h12, 1'b0, 8'h00, 1'b0);
    access(1'b1, 4'h0, 8'h34, 1'b0, 8'h00, 1'b0);
    access(1'b0, 4'h4, 8'h00, 1'b0, 8'h00, 1'b0); idle();
    access(1'b0, 4'h9, 8'h00, 1'b0, 8'h00, 1'b0); idle();  // R11 misaligned
    access(1'b0, 4'hC, 8'h00, 1'b0, 8'h00, 1'b0); idle();  // R9 readback
    access(1'b1, 4'hC, 8'h03, 1'b0, 8'h00, 1'b0);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] a = {2'($urandom_range(0, 3)), 2'b00};
      if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
      access(1'($urandom_range(0, 1)), a, 8'($urandom), $urandom_range(0, 3) == 0,
             8'($urandom), $urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) idle();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule